// File: doc/BRIEF.md
# Indirect Bus Host Strobe Sequencer

This block is the host side of a 16-bit indirect parallel bus in the 68 style. The user side hands it one transfer at a time over a request/ready handshake. Each request carries a direction, a one-bit register-select (address) bit and, for writes, a data word. The sequencer then drives the peripheral's address bit, its read/write line, chip select and one of two active-low byte strobes. A write uses the upper-byte strobe. A read uses the lower-byte strobe. The transfer ends with a one-cycle acknowledge, and on reads the captured word comes back with it.

The peripheral's memory clock can run at the bus clock or at 1/2, 1/3 or 1/4 of it. A two-bit ratio setting, latched when a request is accepted, sets the read strobe length, the cycle in which read data is sampled and the turnaround gap after a write. Every half-cycle timing figure is rounded up to a whole clock, and the whole block runs on the single bus clock. Each strobe phase and each turnaround is timed by one loadable down-counter.

Top module: `ibs_seq`

## Requirements
- R1: During a write only `bus_cs_n` and `bus_ub_n` go low (together), and `bus_lb_n` stays high. During a read only `bus_cs_n` and `bus_lb_n` go low, and `bus_ub_n` stays high.
- R2: For a write, `bus_oe` is 1 and `bus_dout` holds the accepted write word from the cycle after acceptance until `ready` returns. This covers the whole strobe plus at least one cycle after the strobe rises.
- R3: The write strobe stays low for exactly 4 clock cycles, whatever the ratio.
- R4: The read strobe stays low for 8, 11, 15 or 17 cycles for ratio codes 0, 1, 2 and 3 (divide by 1, 2, 3 and 4).
- R5: Read data is sampled from `bus_din` at the clock edge 8, 10, 13 or 17 cycles after the read strobe went low (ratio code 0 to 3). A value on `bus_din` at any earlier edge has no effect on `rsp_rdata`.
- R6: During a read transfer `bus_oe` stays 0.
- R7: `bus_a0` and `bus_rw_n` (1 = read, 0 = write) take the request's values one cycle before the strobe falls. They keep those values until the next request is accepted.
- R8: After the strobe rises, `ready` returns after 3, 6, 8 or 10 cycles for a write (ratio code 0 to 3) and after 3 cycles for a read.
- R9: `ready` is 0 from the cycle after acceptance until the turnaround ends. A request, and any change of `cfg_ratio`, presented while `ready` is 0 has no effect on the transfer in progress.
- R10: `ack` is high for exactly one cycle, the cycle right after the strobe rises. During that cycle `rsp_rdata` holds the word read.
- R11: A synchronous active-high reset drives all strobes high, clears `bus_oe` and `ack`, sets `ready`, and abandons any transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ratio | input | 2 | Memory-clock ratio code: 0 = 1/1, 1 = 1/2, 2 = 1/3, 3 = 1/4 |
| req | input | 1 | Transfer request, taken when `ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_a0 | input | 1 | Register-select bit for the transfer |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | Sequencer can accept a request |
| ack | output | 1 | One-cycle transfer completion pulse |
| rsp_rdata | output | 16 | Data captured by the last read |
| bus_a0 | output | 1 | Address bit to the peripheral |
| bus_rw_n | output | 1 | Direction to the peripheral, 1 = read |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ub_n | output | 1 | Upper-byte (write) strobe, active low |
| bus_lb_n | output | 1 | Lower-byte (read) strobe, active low |
| bus_dout | output | 16 | Data driven to the bus |
| bus_oe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | 16 | Data returned by the peripheral |

## Verification
The hardest thing to show from the ports is that read data is taken at exactly the rounded data-valid edge and at no earlier one, because a sampler that is one cycle early looks correct when the bus holds steady data. The bench's peripheral model counts the read strobe's low cycles and drives a junk pattern until the exact edge, so an early sample returns junk. A second hard case is a request kept high, with other data and a new ratio, while a transfer is busy. The stimulus does this during several transfers and also resets the block in the middle of a read strobe.

// File: rtl/ibs_pkg.sv
package ibs_pkg;
  localparam int RATIO_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_TURN   = 2'd3
  } ibs_state_t;

  // Strobe low length in bus clocks, rounded up.
  function automatic int strobe_cycles(input logic [RATIO_W-1:0] r, input logic wr);
    if (wr) return 4;
    case (r)
      2'd0:    return 8;
      2'd1:    return 11;
      2'd2:    return 15;
      default: return 17;
    endcase
  endfunction

  // Edge (counted from strobe fall) at which read data is valid.
  function automatic int sample_cycles(input logic [RATIO_W-1:0] r);
    case (r)
      2'd0:    return 8;
      2'd1:    return 10;
      2'd2:    return 13;
      default: return 17;
    endcase
  endfunction

  // Inactive gap after the strobe rises.
  function automatic int turn_cycles(input logic [RATIO_W-1:0] r, input logic wr);
    if (!wr) return 3;
    case (r)
      2'd0:    return 3;
      2'd1:    return 6;
      2'd2:    return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/ibs_timing.sv
module ibs_timing
  import ibs_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [RATIO_W-1:0] ratio,
  input  logic               is_write,
  output logic [CNT_W-1:0]   act_last,
  output logic [CNT_W-1:0]   smp_left,
  output logic [CNT_W-1:0]   turn_last
);
  int act_n, smp_n, turn_n;

  always_comb begin
    act_n     = strobe_cycles(ratio, is_write);
    smp_n     = sample_cycles(ratio);
    turn_n    = turn_cycles(ratio, is_write);
    act_last  = CNT_W'(act_n - 1);
    smp_left  = CNT_W'(act_n - smp_n);
    turn_last = CNT_W'(turn_n - 1);
  end
endmodule

// File: rtl/ibs_timer.sv
module ibs_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (!zero) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ibs_data.sv
module ibs_data #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          latch,
  input  logic [DW-1:0] wdata_in,
  input  logic          capture,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (latch)   wdata_q <= wdata_in;
      if (capture) rdata_q <= din;
    end
  end
endmodule

// File: rtl/ibs_seq.sv
module ibs_seq
  import ibs_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic               req,
  input  logic               req_write,
  input  logic               req_a0,
  input  logic [DW-1:0]      req_wdata,
  output logic               ready,
  output logic               ack,
  output logic [DW-1:0]      rsp_rdata,
  output logic               bus_a0,
  output logic               bus_rw_n,
  output logic               bus_cs_n,
  output logic               bus_ub_n,
  output logic               bus_lb_n,
  output logic [DW-1:0]      bus_dout,
  output logic               bus_oe,
  input  logic [DW-1:0]      bus_din
);
  ibs_state_t         state;
  logic               lat_write;
  logic [RATIO_W-1:0] lat_ratio;
  logic [CNT_W-1:0]   act_last, smp_left, turn_last;
  logic [CNT_W-1:0]   tmr_cnt, tmr_val;
  logic               tmr_zero, tmr_load;
  logic               take, grab;

  assign take     = (state == ST_IDLE) && req;
  assign tmr_load = (state == ST_SETUP) || ((state == ST_ACTIVE) && tmr_zero);
  assign tmr_val  = (state == ST_SETUP) ? act_last : turn_last;
  assign grab     = (state == ST_ACTIVE) && !lat_write && (tmr_cnt == smp_left);

  ibs_timing #(.CNT_W(CNT_W)) u_timing (
    .ratio    (lat_ratio),
    .is_write (lat_write),
    .act_last (act_last),
    .smp_left (smp_left),
    .turn_last(turn_last)
  );

  ibs_timer #(.W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .cnt     (tmr_cnt),
    .zero    (tmr_zero)
  );

  ibs_data #(.DW(DW)) u_data (
    .clk     (clk),
    .rst     (rst),
    .latch   (take),
    .wdata_in(req_wdata),
    .capture (grab),
    .din     (bus_din),
    .wdata_q (bus_dout),
    .rdata_q (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ready     <= 1'b1;
      ack       <= 1'b0;
      bus_a0    <= 1'b0;
      bus_rw_n  <= 1'b1;
      bus_cs_n  <= 1'b1;
      bus_ub_n  <= 1'b1;
      bus_lb_n  <= 1'b1;
      bus_oe    <= 1'b0;
      lat_write <= 1'b0;
      lat_ratio <= '0;
    end else begin
      ack <= 1'b0;
      unique case (state)
        ST_IDLE: if (req) begin
          state     <= ST_SETUP;
          ready     <= 1'b0;
          bus_a0    <= req_a0;
          bus_rw_n  <= !req_write;
          bus_oe    <= req_write;
          lat_write <= req_write;
          lat_ratio <= cfg_ratio;
        end
        ST_SETUP: begin
          state    <= ST_ACTIVE;
          bus_cs_n <= 1'b0;
          bus_ub_n <= !lat_write;
          bus_lb_n <= lat_write;
        end
        ST_ACTIVE: if (tmr_zero) begin
          state    <= ST_TURN;
          bus_cs_n <= 1'b1;
          bus_ub_n <= 1'b1;
          bus_lb_n <= 1'b1;
          ack      <= 1'b1;
        end
        ST_TURN: if (tmr_zero) begin
          state  <= ST_IDLE;
          ready  <= 1'b1;
          bus_oe <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ibs_seq_chk.sv
module ibs_seq_chk (
  input logic clk,
  input logic rst,
  input logic ready,
  input logic ack,
  input logic bus_a0,
  input logic bus_rw_n,
  input logic bus_cs_n,
  input logic bus_ub_n,
  input logic bus_lb_n,
  input logic bus_oe
);
  logic [5:0] ub_run;

  always_ff @(posedge clk) begin
    if (rst)            ub_run <= '0;
    else if (!bus_ub_n) ub_run <= ub_run + 1'b1;
    else                ub_run <= '0;
  end

  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    !(!bus_ub_n && !bus_lb_n) && ((!bus_ub_n || !bus_lb_n) == !bus_cs_n));

  assert_write_len_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ub_n) |-> (ub_run == 6'd4));

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_lb_n |-> !bus_oe);

  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_a0) && $stable(bus_rw_n)));

  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_cs_n |-> !ready);

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  assert_reset_idle_R11: assert property (@(posedge clk)
    rst |=> (bus_cs_n && bus_ub_n && bus_lb_n && !bus_oe && !ack && ready));
endmodule

bind ibs_seq ibs_seq_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .ready   (ready),
  .ack     (ack),
  .bus_a0  (bus_a0),
  .bus_rw_n(bus_rw_n),
  .bus_cs_n(bus_cs_n),
  .bus_ub_n(bus_ub_n),
  .bus_lb_n(bus_lb_n),
  .bus_oe  (bus_oe)
);

// File: tb/sim_ibs_seq.sv
`timescale 1ns/1ps
module sim_ibs_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_ratio = 2'd0;
  logic        req = 1'b0, req_write = 1'b0, req_a0 = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [15:0] bus_din = 16'hBAD0;
  logic        ready, ack, bus_a0, bus_rw_n, bus_cs_n, bus_ub_n, bus_lb_n, bus_oe;
  logic [15:0] rsp_rdata, bus_dout;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  int          m_st = 0, m_el = 0;
  bit          m_w = 0, m_a0 = 0, m_ack = 0, m_acc = 0;
  logic [1:0]  m_r = 0;
  logic [15:0] m_wd = 0, m_rd = 0;
  // peripheral model
  int          p_low = 0;
  logic [1:0]  p_ratio = 0;
  logic [15:0] p_val = 0;

  always #4 clk = ~clk;

  ibs_seq u0 (.clk(clk), .rst(rst), .cfg_ratio(cfg_ratio), .req(req), .req_write(req_write),
    .req_a0(req_a0), .req_wdata(req_wdata), .ready(ready), .ack(ack), .rsp_rdata(rsp_rdata),
    .bus_a0(bus_a0), .bus_rw_n(bus_rw_n), .bus_cs_n(bus_cs_n), .bus_ub_n(bus_ub_n),
    .bus_lb_n(bus_lb_n), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din));

  function automatic int f_act(bit w, logic [1:0] r);
    if (w) return 4;
    return (r == 0) ? 8 : (r == 1) ? 11 : (r == 2) ? 15 : 17;
  endfunction
  function automatic int f_smp(logic [1:0] r);
    return (r == 0) ? 8 : (r == 1) ? 10 : (r == 2) ? 13 : 17;
  endfunction
  function automatic int f_turn(bit w, logic [1:0] r);
    if (!w) return 3;
    return (r == 0) ? 3 : (r == 1) ? 6 : (r == 2) ? 8 : 10;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    m_acc = 0;
    if (rst) begin
      m_st = 0; m_el = 0; m_w = 0; m_a0 = 0; m_ack = 0; m_r = 0; m_wd = 0; m_rd = 0;
    end else begin
      m_ack = 0;
      case (m_st)
        0: if (req) begin
          m_st = 1; m_w = req_write; m_a0 = req_a0; m_r = cfg_ratio; m_wd = req_wdata; m_acc = 1;
        end
        1: begin m_st = 2; m_el = 0; end
        2: begin
          m_el++;
          if (!m_w && m_el == f_smp(m_r)) m_rd = bus_din;
          if (m_el == f_act(m_w, m_r)) begin m_st = 3; m_el = 0; m_ack = 1; end
        end
        default: begin
          m_el++;
          if (m_el == f_turn(m_w, m_r)) begin m_st = 0; m_el = 0; end
        end
      endcase
    end
  endtask

  task automatic compare();
    bit act_ph;
    act_ph = (m_st == 2);
    chk(bus_cs_n == !act_ph, "R1 cs_n", bus_cs_n, !act_ph);
    chk(bus_ub_n == !(act_ph && m_w), "R1 R3 ub_n", bus_ub_n, !(act_ph && m_w));
    chk(bus_lb_n == !(act_ph && !m_w), "R1 R4 lb_n", bus_lb_n, !(act_ph && !m_w));
    chk(bus_oe == (m_w && m_st != 0), "R2 R6 oe", bus_oe, (m_w && m_st != 0));
    if (m_w && m_st != 0) chk(bus_dout == m_wd, "R2 dout", bus_dout, m_wd);
    chk(bus_a0 == m_a0, "R7 a0", bus_a0, m_a0);
    chk(bus_rw_n == !m_w, "R7 rw_n", bus_rw_n, !m_w);
    chk(ready == (m_st == 0), "R8 R9 ready", ready, (m_st == 0));
    chk(ack == m_ack, "R10 ack", ack, m_ack);
    chk(rsp_rdata == m_rd, "R5 rdata", rsp_rdata, m_rd);
  endtask

  // one clock: peripheral drive, edge, model, compare at the falling edge
  task automatic cycle();
    p_low   = bus_lb_n ? 0 : p_low + 1;
    bus_din = (p_low >= f_smp(p_ratio)) ? p_val : (16'hBAD0 ^ 16'(p_low));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    cyc++;
  endtask

  task automatic xfer(bit w, bit a, logic [15:0] d, logic [1:0] r, int hold);
    cfg_ratio = r; req = 1; req_write = w; req_a0 = a; req_wdata = d;
    p_ratio = r; p_val = d;
    cycle();
    while (!m_acc) cycle();
    // keep a conflicting request and a new ratio while busy (R9)
    req_write = !w; req_a0 = !a; req_wdata = ~d; cfg_ratio = ~r;
    for (int i = 0; i < hold; i++) cycle();
    req = 0;
    while (m_st != 0) cycle();
    if (!w) chk(rsp_rdata == d, "R5 read word", rsp_rdata, d);
    cycle();
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) cycle();
    chk(ready && bus_cs_n && !bus_oe && !ack, "R11 reset state", {ready, bus_cs_n, bus_oe, ack}, 4'b1100);
    rst = 0;
    cycle();
    for (int r = 0; r < 4; r++) begin
      xfer(1, r[0], 16'h1234 + 16'(r), 2'(r), 0);
      xfer(0, !r[0], 16'hA5C0 + 16'(r), 2'(r), 0);
    end
    for (int r = 0; r < 4; r++) begin
      xfer(0, 1, 16'h0F0F ^ 16'(r << 4), 2'(r), 5);
      xfer(1, 0, 16'hF00D ^ 16'(r), 2'(r), 5);
    end
    // back to back with request held continuously
    cfg_ratio = 2'd1; req = 1; req_write = 0; req_a0 = 1; p_ratio = 2'd1; p_val = 16'h5A5A;
    for (int i = 0; i < 60; i++) cycle();
    req = 0;
    while (m_st != 0) cycle();
    // reset in the middle of a read strobe
    cfg_ratio = 2'd3; req = 1; req_write = 0; req_a0 = 0; p_ratio = 2'd3; p_val = 16'h7777;
    cycle();
    req = 0;
    for (int i = 0; i < 6; i++) cycle();
    rst = 1;
    cycle();
    rst = 0;
    chk(bus_cs_n && bus_lb_n && ready && !bus_oe, "R11 mid-transfer reset",
        {bus_cs_n, bus_lb_n, ready, bus_oe}, 4'b1110);
    for (int i = 0; i < 4; i++) cycle();
    xfer(0, 1, 16'hC3C3, 2'd2, 2);
    summary();
  end
endmodule